// File: doc/BRIEF.md
# Scanline Event Scheduler

This block sits beside a console CPU core and produces the timing events that recur on every scanline. It advances once per CPU step, where each step stands for two master clocks. The video counters (horizontal position in master clocks, vertical line number) and the number of visible lines come from outside. So do a chip-revision select and two summary flags from the HDMA channels: any channel enabled, and any channel still active.

From these inputs it drives five outputs:
- a stall level that covers the DRAM refresh window;
- an ALU step pulse once per 8-clock refresh group;
- a strobe that tells the interrupt logic to poll;
- an HDMA request pulse;
- a mode bit that says whether the request is for setup or for a run.

A free-running phase counter tracks the CPU clock modulo the 8-clock DMA grid. Trigger positions are captured from that phase at each line start, so events stay aligned to the grid. The correction depends on the revision.

Top module: `scanline_event_sched`

## Requirements
- R1: A phase counter holds the master-clock count modulo 8. It is 0 after reset and adds 2 on each cycle with `step_i` high. Every position captured at a line start uses the phase value from just before that step. A line start is a step with `hcount_i` equal to 0.
- R2: On the cycle after a step whose `hcount_i` has bit 1 set, `poll_o` is 1. On every other cycle `poll_o` is 0.
- R3: Every line start fixes that line's refresh position, and refresh begins on the first step whose `hcount_i` is at or above it. With `rev2_i`=1 the position is 538 minus the phase. With `rev2_i`=0 it is the parameter REF_FIXED, which defaults to 546.
- R4: `stall_o` rises on the cycle after the refresh start step. It then stays high for exactly 20 steps, or 40 master clocks, so it is high after the steps at hcount h0, h0+2, up to h0+38.
- R5: `alu_step_o` pulses once after each group of 4 refresh steps (8 master clocks). The pulses follow the steps at h0+6, h0+14, h0+22, h0+30 and h0+38, which makes five pulses per window.
- R6: The setup trigger is armed only at the line start of line 0. Its position is 12 plus the phase with `rev2_i`=1, and 20 minus the phase with `rev2_i`=0. When it fires with `hdma_any_en_i`=1, the next cycle shows `hdma_req_o`=1 and `hdma_mode_o`=0.
- R7: On a line whose `vcount_i` is below `vis_lines_i`, the run trigger sits at hcount 1104. When it fires with `hdma_any_act_i`=1, the next cycle shows `hdma_req_o`=1 and `hdma_mode_o`=1.
- R8: Each trigger fires at most once per arming. Setup is armed once per frame, while refresh and run are armed once per line. `hdma_req_o` is a single-cycle pulse and never rises outside those firings.
- R9: A cycle with `step_i` low advances no state. On the cycle after it, `poll_o`, `alu_step_o` and `hdma_req_o` are 0, and `stall_o` keeps its previous value.
- R10: Synchronous reset drives all outputs to 0 and disarms all three triggers. No refresh, setup or run event occurs until the next line start re-arms them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One CPU step (2 master clocks) happens this cycle |
| hcount_i | input | HCNT_W | Horizontal position in master clocks |
| vcount_i | input | VCNT_W | Current line number |
| vis_lines_i | input | VCNT_W | Number of visible lines |
| rev2_i | input | 1 | 1 selects revision-2 positioning, 0 revision 1 |
| hdma_any_en_i | input | 1 | Some HDMA channel is enabled |
| hdma_any_act_i | input | 1 | Some HDMA channel is still active |
| stall_o | output | 1 | CPU stall level during DRAM refresh |
| alu_step_o | output | 1 | ALU step pulse per 8-clock refresh group |
| poll_o | output | 1 | Interrupt poll strobe |
| hdma_req_o | output | 1 | HDMA request pulse |
| hdma_mode_o | output | 1 | Request mode: 0 setup, 1 run |

## Verification
The bench builds the block with its default parameters: an 8-clock grid, a 2-clock step, REF_FIXED at 546 and the run position at 1104.

Short frames are formed by driving lines 0 to 2 with visible-line counts from 0 to 3. Before line 0, 0 to 3 lead-in steps shift the phase, and because one line is 4 modulo 8 master clocks, the phase at line 1 differs again. Together these bring every even phase under both revision formulas within reach.

Idle gaps inside a refresh window, and a reset taken mid-window, cover the hold and disarm behaviour.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic {
        HDMA_SETUP = 1'b0,
        HDMA_RUN   = 1'b1
    } hdma_mode_e;

    typedef struct packed {
        logic       req;
        hdma_mode_e mode;
    } hdma_evt_t;

    // trigger slice indices
    parameter int TRG_REF = 0;
    parameter int TRG_SET = 1;
    parameter int TRG_RUN = 2;
    parameter int NUM_TRG = 3;

    // refresh start: grid-corrected on revision 2, fixed on revision 1
    function automatic int refresh_start(input logic rev2, input int phase,
                                         input int base, input int grid,
                                         input int fixed_pos);
        return rev2 ? (base + grid - phase) : fixed_pos;
    endfunction

    // setup start: the phase correction runs in opposite directions per revision
    function automatic int setup_start(input logic rev2, input int phase,
                                       input int base, input int grid);
        return rev2 ? (base + phase) : (base + grid - phase);
    endfunction

endpackage

// File: rtl/sched_phase.sv
module sched_phase #(
    parameter int GRID = 8,
    parameter int STEP = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    step_i,
    output logic [$clog2(GRID)-1:0] phase_o
);
    localparam int PH_W = $clog2(GRID);

    logic [PH_W-1:0] phase_q;
    logic [PH_W:0]   sum_w;

    assign sum_w = {1'b0, phase_q} + (PH_W+1)'(STEP);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= '0;
        end else if (step_i) begin
            if (sum_w >= (PH_W+1)'(GRID)) begin
                phase_q <= PH_W'(sum_w - (PH_W+1)'(GRID));
            end else begin
                phase_q <= PH_W'(sum_w);
            end
        end
    end

    assign phase_o = phase_q;

    AST_PHASE_ON_STEP_GRID: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q % PH_W'(STEP)) == '0); // R1

    AST_PHASE_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(phase_q)); // R9

endmodule

// File: rtl/sched_once.sv
module sched_once #(
    parameter int HCNT_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic              reload_i,
    input  logic [HCNT_W-1:0] pos_i,
    input  logic [HCNT_W-1:0] hcount_i,
    output logic              fire_o
);
    logic [HCNT_W-1:0] pos_q;
    logic              done_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q  <= '0;
            done_q <= 1'b1;
        end else if (reload_i) begin
            pos_q  <= pos_i;
            done_q <= 1'b0;
        end else if (fire_o) begin
            done_q <= 1'b1;
        end
    end

    always_comb begin
        fire_o = step_i && !reload_i && !done_q && (hcount_i >= pos_q);
    end

    AST_FIRE_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |=> done_q); // R8

    AST_FIRE_NEEDS_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        fire_o |-> step_i); // R9

endmodule

// File: rtl/sched_refresh.sv
module sched_refresh #(
    parameter int REF_STEPS   = 20,
    parameter int GROUP_STEPS = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    input  logic start_i,
    output logic stall_o,
    output logic alu_o
);
    localparam int IDX_W = $clog2(REF_STEPS + 1);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_inc;
    logic             alu_q;

    assign idx_inc = idx_q + IDX_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            alu_q    <= 1'b0;
        end else begin
            alu_q <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
                idx_q    <= IDX_W'(1);
            end else if (active_q && step_i) begin
                if (idx_q == IDX_W'(REF_STEPS)) begin
                    active_q <= 1'b0;
                    idx_q    <= '0;
                end else begin
                    idx_q <= idx_inc;
                    alu_q <= (idx_inc % IDX_W'(GROUP_STEPS)) == '0;
                end
            end
        end
    end

    assign stall_o = active_q;
    assign alu_o   = alu_q;

    AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        active_q |-> (idx_q != '0 && idx_q <= IDX_W'(REF_STEPS))); // R4

    AST_ALU_IN_STALL: assert property (@(posedge clk_i) disable iff (rst_i)
        alu_q |-> active_q); // R5

    AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |-> !active_q); // R8

endmodule

// File: rtl/scanline_event_sched.sv
module scanline_event_sched
    import sched_pkg::*;
#(
    parameter int HCNT_W     = 11,
    parameter int VCNT_W     = 9,
    parameter int DMA_GRID   = 8,
    parameter int STEP_CLKS  = 2,
    parameter int REF_BASE   = 530,
    parameter int REF_FIXED  = 546,
    parameter int SETUP_BASE = 12,
    parameter int RUN_POS    = 1104,
    parameter int REF_CLKS   = 40,
    parameter int GROUP_CLKS = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic [HCNT_W-1:0] hcount_i,
    input  logic [VCNT_W-1:0] vcount_i,
    input  logic [VCNT_W-1:0] vis_lines_i,
    input  logic              rev2_i,
    input  logic              hdma_any_en_i,
    input  logic              hdma_any_act_i,
    output logic              stall_o,
    output logic              alu_step_o,
    output logic              poll_o,
    output logic              hdma_req_o,
    output logic              hdma_mode_o
);
    localparam int PH_W        = $clog2(DMA_GRID);
    localparam int REF_STEPS   = REF_CLKS / STEP_CLKS;
    localparam int GROUP_STEPS = GROUP_CLKS / STEP_CLKS;

    logic [PH_W-1:0]    phase_w;
    logic               line_start;
    logic [NUM_TRG-1:0] reload_w;
    logic [NUM_TRG-1:0] fire_w;
    logic [HCNT_W-1:0]  pos_w [NUM_TRG];
    hdma_evt_t          evt_q;
    logic               poll_q;

    sched_phase #(.GRID(DMA_GRID), .STEP(STEP_CLKS)) u_phase (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (step_i),
        .phase_o (phase_w)
    );

    assign line_start = step_i && (hcount_i == '0);

    always_comb begin
        reload_w[TRG_REF] = line_start;
        reload_w[TRG_SET] = line_start && (vcount_i == '0);
        reload_w[TRG_RUN] = line_start && (vcount_i < vis_lines_i);
        pos_w[TRG_REF] = HCNT_W'(refresh_start(rev2_i, int'(phase_w), REF_BASE,
                                               DMA_GRID, REF_FIXED));
        pos_w[TRG_SET] = HCNT_W'(setup_start(rev2_i, int'(phase_w), SETUP_BASE,
                                             DMA_GRID));
        pos_w[TRG_RUN] = HCNT_W'(RUN_POS);
    end

    for (genvar g = 0; g < NUM_TRG; g++) begin : g_trg
        sched_once #(.HCNT_W(HCNT_W)) u_once (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .step_i   (step_i),
            .reload_i (reload_w[g]),
            .pos_i    (pos_w[g]),
            .hcount_i (hcount_i),
            .fire_o   (fire_w[g])
        );
    end

    sched_refresh #(.REF_STEPS(REF_STEPS), .GROUP_STEPS(GROUP_STEPS)) u_refresh (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (step_i),
        .start_i (fire_w[TRG_REF]),
        .stall_o (stall_o),
        .alu_o   (alu_step_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            evt_q  <= '{req: 1'b0, mode: HDMA_SETUP};
            poll_q <= 1'b0;
        end else begin
            poll_q    <= step_i && hcount_i[1];
            evt_q.req <= (fire_w[TRG_SET] && hdma_any_en_i)
                      || (fire_w[TRG_RUN] && hdma_any_act_i);
            if (fire_w[TRG_RUN] && hdma_any_act_i) begin
                evt_q.mode <= HDMA_RUN;
            end else if (fire_w[TRG_SET] && hdma_any_en_i) begin
                evt_q.mode <= HDMA_SETUP;
            end
        end
    end

    assign poll_o      = poll_q;
    assign hdma_req_o  = evt_q.req;
    assign hdma_mode_o = evt_q.mode;

    AST_POLL_NEEDS_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        poll_o |-> $past(step_i)); // R2

    AST_RUN_AFTER_POS: assert property (@(posedge clk_i) disable iff (rst_i)
        (hdma_req_o && hdma_mode_o) |-> ($past(hcount_i) >= HCNT_W'(RUN_POS))); // R7

    AST_SETUP_ON_LINE0: assert property (@(posedge clk_i) disable iff (rst_i)
        (hdma_req_o && !hdma_mode_o) |-> ($past(vcount_i) == '0)); // R6

    AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        hdma_req_o |=> !hdma_req_o); // R8

endmodule

// File: tb/scanline_event_sched_tb_top.sv
`timescale 1ns/1ps
module scanline_event_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [10:0] hcount = '0;
    logic [8:0]  vcount = '0;
    logic [8:0]  vis = '0;
    logic        rev2 = 1'b0;
    logic        en = 1'b0;
    logic        act = 1'b0;
    logic        stall, alu, poll, req, mode;

    int  tests = 0;
    int  fails = 0;
    bit  finished = 0;
    int  bp, ref_h, set_h, run_h;
    bit  post_rst;
    int  prev_stall;

    typedef struct packed {
        logic       rev2;
        logic [1:0] pre;
        logic       en;
        logic       act;
        logic [8:0] vis;
        logic       gap;
    } scen_t;

    localparam int NSCN = 6;
    localparam scen_t SCN [NSCN] = '{
        '{1'b1, 2'd0, 1'b1, 1'b1, 9'd3, 1'b0},
        '{1'b1, 2'd1, 1'b1, 1'b0, 9'd1, 1'b1},
        '{1'b0, 2'd2, 1'b0, 1'b1, 9'd3, 1'b0},
        '{1'b0, 2'd3, 1'b1, 1'b1, 9'd0, 1'b1},
        '{1'b1, 2'd3, 1'b1, 1'b1, 9'd2, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b1, 9'd3, 1'b0}
    };

    scanline_event_sched dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .step_i         (step),
        .hcount_i       (hcount),
        .vcount_i       (vcount),
        .vis_lines_i    (vis),
        .rev2_i         (rev2),
        .hdma_any_en_i  (en),
        .hdma_any_act_i (act),
        .stall_o        (stall),
        .alu_step_o     (alu),
        .poll_o         (poll),
        .hdma_req_o     (req),
        .hdma_mode_o    (mode)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input int act_v, input int exp_v);
        tests++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)",
                     tag, act_v, exp_v, hcount, vcount);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        step = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bp = 0; ref_h = -1; set_h = -1; run_h = -1;
        post_rst = 1; prev_stall = 0;
        check("R10 stall", int'(stall), 0);
        check("R10 alu", int'(alu), 0);
        check("R10 poll", int'(poll), 0);
        check("R10 req", int'(req), 0);
    endtask

    task automatic do_step(input int h, input int v);
        int p, e_stall, e_alu, e_req;
        string t_st, t_rq;
        if (h == 0) begin
            post_rst = 0;
            p = bp;
            ref_h = rev2 ? 538 - p : 546;
            set_h = (v == 0) ? (rev2 ? 12 + p : 20 - p) : -1;
            run_h = (v < int'(vis)) ? 1104 : -1;
        end
        bp = (bp + 2) % 8;
        step   = 1'b1;
        hcount = 11'(h);
        vcount = 9'(v);
        @(posedge clk);
        @(negedge clk);
        e_stall = (ref_h >= 0 && h >= ref_h && h <= ref_h + 38) ? 1 : 0;
        e_alu   = (ref_h >= 0 && h >= ref_h + 6 && h <= ref_h + 38
                   && ((h - ref_h - 6) % 8) == 0) ? 1 : 0;
        e_req   = ((h == set_h && en) || (h == run_h && act)) ? 1 : 0;
        if (post_rst)        t_st = "R10 stall";
        else if (h == ref_h) t_st = (v == 1) ? "R1 stall" : "R3 stall";
        else                 t_st = "R4 stall";
        if (post_rst)        t_rq = "R10 req";
        else if (h == set_h) t_rq = "R6 req";
        else if (h == run_h) t_rq = "R7 req";
        else                 t_rq = "R8 req";
        check(t_st, int'(stall), e_stall);
        check("R5 alu", int'(alu), e_alu);
        check("R2 poll", int'(poll), (h % 4) == 2 ? 1 : 0);
        check(t_rq, int'(req), e_req);
        if (e_req == 1) begin
            check((h == run_h) ? "R7 mode" : "R6 mode", int'(mode),
                  (h == run_h) ? 1 : 0);
        end
        prev_stall = e_stall;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            step = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check("R9 stall", int'(stall), prev_stall);
            check("R9 alu", int'(alu), 0);
            check("R9 poll", int'(poll), 0);
            check("R9 req", int'(req), 0);
        end
    endtask

    task automatic run_line(input int v, input bit gap);
        for (int h = 0; h < 1364; h += 2) begin
            do_step(h, v);
            if (gap && h == 560) idle(3);
        end
    endtask

    initial begin
        for (int s = 0; s < NSCN; s++) begin
            rev2 = SCN[s].rev2;
            en   = SCN[s].en;
            act  = SCN[s].act;
            vis  = SCN[s].vis;
            do_reset();
            for (int k = 0; k < int'(SCN[s].pre); k++) begin
                do_step(1364 - 2 * (int'(SCN[s].pre) - k), 300);
            end
            for (int v = 0; v < 3; v++) run_line(v, SCN[s].gap);
        end

        // directed: reset in the middle of a refresh window, then re-arm
        rev2 = 1'b1; en = 1'b1; act = 1'b1; vis = 9'd3;
        do_reset();
        for (int h = 0; h <= 540; h += 2) do_step(h, 0);
        do_reset();
        for (int h = 542; h < 1364; h += 2) do_step(h, 0);
        run_line(1, 1'b0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule